// File: doc/BRIEF.md
# Pushbutton Memory Browser and Byte Editor

This block lets a user look through and change a small on-chip memory of sixteen bytes with four pushbuttons. It shows the result on three seven-segment digits. A 4-bit pointer picks the location. Two buttons move the pointer up or down, and the other two add or subtract one from the byte stored at that location. One digit shows the pointer as a hex character. The other two show the stored byte as two hex characters.

The press inputs are one-cycle pulses from an external debouncer. The memory lives inside the block. It writes on the clock edge and registers its read address, so read data belongs to the address presented one edge earlier. A data edit is therefore a read-modify-write. The press is taken on one edge and the write goes out in the following cycle, when the read data matches the pointer. After reset a sweep writes zero to every location before any press is accepted.

Top module: `mem_edit_panel`

## Requirements
- R1: A synchronous active-high reset starts a 16-cycle sweep. In those cycles `mem_we` is 1, `mem_wdata` is 0 and `mem_addr` runs 0, 1, up to 15. After the sweep every location reads 00 and the pointer is 0.
- R2: Presses that arrive during the sweep have no effect. The cycle after the sweep shows address 0 with `mem_we` low.
- R3: `press[2]` adds one to the pointer modulo 16, and `press[3]` subtracts one modulo 16. The new value is on `mem_addr` in the cycle after the press.
- R4: `press[0]` adds one to the byte at the pointer modulo 256, and `press[1]` subtracts one (00 becomes FF, FF becomes 00). In the cycle after the press, `mem_we` is high for exactly one cycle at the unchanged address, with `mem_wdata` equal to the old byte plus or minus one.
- R5: Presses that arrive in the cycle in which the edit write is issued have no effect.
- R6: When several bits of `press` are high together, an address step wins over a data edit. Within each pair, the increment bit wins over the decrement bit.
- R7: `seg_addr` shows `mem_addr` as a hex digit. Segments are active low, bit 0 is segment a and bit 6 is segment g, so the digit 1 is 1111001.
- R8: `seg_hi` and `seg_lo` show the upper and lower nibble of the byte stored at `mem_addr`, in the same encoding. They are valid from the second cycle after an address change, and from the cycle after an edit write.
- R9: Outside the sweep, `mem_we` stays low and the pointer holds whenever no press arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| press | input | 4 | One-cycle press pulses: 0 data up, 1 data down, 2 address up, 3 address down |
| mem_addr | output | ADDR_W | Address presented to the memory (sweep counter or pointer) |
| mem_wdata | output | DATA_W | Write data presented to the memory |
| mem_we | output | 1 | Memory write enable |
| seg_addr | output | 7 | Active-low segments for the address digit |
| seg_hi | output | 7 | Active-low segments for the upper data nibble |
| seg_lo | output | 7 | Active-low segments for the lower data nibble |

## Verification
Each result is due a different number of cycles after its press. The address output and its digit change one edge after an address press. The write strobe and write data come one edge after an edit press. The data digits settle two edges after an address change, and one edge after the edit write. The bench model keeps a count of cycles since the last pointer change. It compares the data digits only once that count allows, while it checks the address, the strobe and the write data on every sampled cycle.

// File: rtl/mem_edit_panel.sv
module mem_edit_panel #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        press,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [6:0]        seg_addr,
  output logic [6:0]        seg_hi,
  output logic [6:0]        seg_lo
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [1:0] {SWEEP, IDLE, WRITE} phase_t;

  phase_t            phase;
  logic [ADDR_W-1:0] ptr, sweep_ptr, rd_addr_q;
  logic              edit_up;
  logic [DATA_W-1:0] ram [DEPTH];
  logic [DATA_W-1:0] rd_data;

  wire sweeping = (phase == SWEEP);
  wire writing  = (phase == WRITE);
  wire step_any = press[2] | press[3];
  wire edit_any = ~step_any & (press[0] | press[1]);

  function automatic logic [6:0] hex7(input logic [3:0] n);
    case (n)
      4'h0: hex7 = 7'b1000000;
      4'h1: hex7 = 7'b1111001;
      4'h2: hex7 = 7'b0100100;
      4'h3: hex7 = 7'b0110000;
      4'h4: hex7 = 7'b0011001;
      4'h5: hex7 = 7'b0010010;
      4'h6: hex7 = 7'b0000010;
      4'h7: hex7 = 7'b1111000;
      4'h8: hex7 = 7'b0000000;
      4'h9: hex7 = 7'b0010000;
      4'hA: hex7 = 7'b0001000;
      4'hB: hex7 = 7'b0000011;
      4'hC: hex7 = 7'b1000110;
      4'hD: hex7 = 7'b0100001;
      4'hE: hex7 = 7'b0000110;
      default: hex7 = 7'b0001110;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= SWEEP;
      sweep_ptr <= '0;
      ptr       <= '0;
      edit_up   <= 1'b0;
    end else begin
      case (phase)
        SWEEP: begin
          sweep_ptr <= sweep_ptr + 1'b1;
          if (&sweep_ptr) phase <= IDLE;
        end
        IDLE: begin
          if (step_any)
            ptr <= press[2] ? ptr + 1'b1 : ptr - 1'b1;
          else if (edit_any) begin
            phase   <= WRITE;
            edit_up <= press[0];
          end
        end
        default: phase <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    rd_addr_q <= mem_addr;
  end

  assign rd_data   = ram[rd_addr_q];
  assign mem_addr  = sweeping ? sweep_ptr : ptr;
  assign mem_we    = sweeping | writing;
  assign mem_wdata = sweeping ? '0 : (edit_up ? rd_data + 1'b1 : rd_data - 1'b1);

  assign seg_addr = hex7(4'(mem_addr));
  assign seg_hi   = hex7(rd_data[DATA_W-1 -: 4]);
  assign seg_lo   = hex7(rd_data[3:0]);
endmodule

// File: rtl/mem_edit_panel_chk.sv
module mem_edit_panel_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        press,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic              in_sweep,
  input logic              in_write
);
  logic idle;
  assign idle = !in_sweep && !in_write;

  assert_sweep_zero_R1: assert property (@(posedge clk) disable iff (rst)
    in_sweep |-> (mem_we && mem_wdata == '0));

  assert_sweep_walk_R1: assert property (@(posedge clk) disable iff (rst)
    (in_sweep && !(&mem_addr)) |=> (in_sweep && mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  assert_sweep_exit_R2: assert property (@(posedge clk) disable iff (rst)
    (in_sweep && (&mem_addr)) |=> (!mem_we && mem_addr == '0));

  assert_addr_up_R3: assert property (@(posedge clk) disable iff (rst)
    (idle && press[2]) |=> (!mem_we && mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  assert_addr_down_R3: assert property (@(posedge clk) disable iff (rst)
    (idle && press[3] && !press[2]) |=> (!mem_we && mem_addr == ADDR_W'($past(mem_addr) - 1'b1)));

  assert_edit_write_R4: assert property (@(posedge clk) disable iff (rst)
    (idle && !press[2] && !press[3] && (press[0] || press[1])) |=> (mem_we && $stable(mem_addr)));

  assert_write_busy_R5: assert property (@(posedge clk) disable iff (rst)
    in_write |=> (!mem_we && $stable(mem_addr)));

  assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (idle && press == 4'b0000) |=> (!mem_we && $stable(mem_addr)));
endmodule

bind mem_edit_panel mem_edit_panel_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .press(press), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_we(mem_we), .in_sweep(sweeping), .in_write(writing)
);

// File: tb/test_mem_edit_panel.sv
`timescale 1ns/1ps
module test_mem_edit_panel;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] press = 4'b0000;
  logic [3:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       mem_we;
  logic [6:0] seg_addr, seg_hi, seg_lo;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_mem [16];
  logic [3:0] m_ptr;
  logic       m_wr;
  logic [7:0] m_wval;
  int         m_age;

  always #2.5 clk = ~clk;

  mem_edit_panel i_mem_edit_panel (
    .clk(clk), .rst(rst), .press(press), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .seg_addr(seg_addr), .seg_hi(seg_hi), .seg_lo(seg_lo)
  );

  function automatic logic [6:0] seg_of(input logic [3:0] n);
    logic [6:0] lit;
    case (n)
      4'h0: lit = 7'h3F; 4'h1: lit = 7'h06; 4'h2: lit = 7'h5B; 4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66; 4'h5: lit = 7'h6D; 4'h6: lit = 7'h7D; 4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F; 4'h9: lit = 7'h6F; 4'hA: lit = 7'h77; 4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39; 4'hD: lit = 7'h5E; 4'hE: lit = 7'h79; default: lit = 7'h71;
    endcase
    return ~lit;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; press = 4'b0000;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) begin
      check("R1 sweep addr", 32'(mem_addr), 32'(i));
      check("R1 sweep we", 32'(mem_we), 32'd1);
      check("R1 sweep data", 32'(mem_wdata), 32'd0);
      press = 4'($urandom());   // R2: random presses during the sweep
      @(negedge clk);
    end
    check("R2 addr after sweep", 32'(mem_addr), 32'd0);
    check("R2 we after sweep", 32'(mem_we), 32'd0);
    for (int i = 0; i < 16; i++) m_mem[i] = 8'h00;
    m_ptr = 4'd0; m_wr = 1'b0; m_age = 0;
  endtask

  task automatic step(input logic [3:0] p, input string tag);
    if (m_wr) begin
      m_mem[m_ptr] = m_wval;
      m_wr = 1'b0;
    end else if (p[2]) begin
      m_ptr = m_ptr + 4'd1; m_age = 0;
    end else if (p[3]) begin
      m_ptr = m_ptr - 4'd1; m_age = 0;
    end else if (p[0]) begin
      m_wr = 1'b1; m_wval = m_mem[m_ptr] + 8'd1;
    end else if (p[1]) begin
      m_wr = 1'b1; m_wval = m_mem[m_ptr] - 8'd1;
    end
    press = p;
    @(negedge clk);
    check({tag, " addr"}, 32'(mem_addr), 32'(m_ptr));
    check({tag, " we"}, 32'(mem_we), 32'(m_wr));
    if (m_wr) check({tag, " wdata"}, 32'(mem_wdata), 32'(m_wval));
    check("R7 seg_addr", 32'(seg_addr), 32'(seg_of(m_ptr)));
    if (m_age >= 1) begin
      check("R8 seg_hi", 32'(seg_hi), 32'(seg_of(m_mem[m_ptr][7:4])));
      check("R8 seg_lo", 32'(seg_lo), 32'(seg_of(m_mem[m_ptr][3:0])));
    end
    if (m_age < 4) m_age++;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (2) @(negedge clk);
    do_reset();

    step(4'b0100, "R3 up");
    check("R7 digit one", 32'(seg_addr), 32'(7'b1111001));
    step(4'b1000, "R3 down");
    step(4'b1000, "R3 wrap below zero");
    check("R3 wrapped to F", 32'(mem_addr), 32'hF);
    step(4'b0000, "R9 idle");
    step(4'b0010, "R4 dec from 00");
    check("R4 00 minus one", 32'(mem_wdata), 32'hFF);
    step(4'b0000, "R4 commit");
    step(4'b0001, "R4 inc from FF");
    check("R4 FF plus one", 32'(mem_wdata), 32'h00);
    step(4'b0000, "R4 commit");
    step(4'b0001, "R4 inc");
    step(4'b0100, "R5 press during write");
    check("R5 address held", 32'(mem_addr), 32'hF);
    step(4'b0000, "R9 idle");
    step(4'b1111, "R6 all pressed");
    check("R6 step up wins", 32'(mem_addr), 32'h0);
    step(4'b1001, "R6 addr over data");
    step(4'b0011, "R6 inc over dec");
    step(4'b0000, "R6 commit");
    step(4'b0000, "R8 settle");

    for (int i = 0; i < 16; i++) begin
      step(4'b0100, "R3 fill");
      step(4'b0001, "R4 fill");
      step(4'b0000, "R4 commit");
    end
    do_reset();
    for (int i = 0; i < 17; i++) begin
      step(4'b0100, "R1 cleared walk");
      step(4'b0000, "R1 cleared walk");
    end

    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [3:0] p;
      r = int'($urandom_range(0, 9));
      if (r < 3) p = 4'b0000;
      else if (r < 8) p = 4'(1 << $urandom_range(0, 3));
      else p = 4'($urandom());
      step(p, "R3/R4/R5/R6/R9 random");
    end

    for (int i = 0; i < 17; i++) begin
      step(4'b0100, "R8 final walk");
      step(4'b0000, "R8 final walk");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule